// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block turns a stream of time-quantum ticks into the timing of one CAN bit. Each bit is one sync quantum, then a first timing segment of `prop_len + ph1_len` quanta, then a second phase segment of `ph2_len` quanta. The block reports the bus level at the sample point on `rx_bit` with a one-cycle `sample_stb`. It pulses `bit_end_stb` when the bit finishes. A bus-idle qualifier selects between two behaviours on a recessive-to-dominant edge. When the bus is idle, the edge restarts the bit outright. During a frame, the edge trims the running phase, by at most the jump width.

The bit position is an index from 0 (the sync quantum) to L-1, where L = 1 + prop + ph1 + ph2. Quantum index T1 = prop + ph1 is the last quantum of the first segment. An edge seen at a tick is taken to occur at the start of the quantum being entered, index n = pos+1, where an index equal to L counts as 0. A correction re-times the bit by moving this index. A late edge moves it back, which stretches the bit. An early edge moves it forward, which trims the bit.

Top module: `can_bit_timing`

## Requirements
- R1: `cfg_err` is a register that takes, on every clock, the result of the configuration check. The check fails when `ph2_len` < 2, when `sjw_len` is 0, when `sjw_len` > `ph2_len`, or when `prop_len + ph1_len` is 0. While the check fails, no strobe fires, `rx_bit` holds, and the bit position is held at index 0.
- R2: With no edges, a bit lasts L ticks. `bit_end_stb` is high for the one cycle after the tick that leaves index L-1, and that tick takes the position to index 0.
- R3: `sample_stb` is high for the one cycle after the tick that leaves index T1. In that same cycle `rx_bit` shows `rx_lvl` as it was at that tick (1 = recessive, 0 = dominant). `rx_bit` changes at no other time.
- R4: Only clock cycles with `tq_en` high advance timing or detect edges. A level change on `rx_lvl` that is undone before the next tick has no effect, and a strobe follows only a tick.
- R5: An edge is `rx_lvl` = 1 at the previous tick and 0 at this tick. If `bus_idle` is high at that tick, the next quantum is index 0 (hard sync). No strobe follows that tick, and the per-bit correction and sample history are cleared.
- R6: A late edge, with `bus_idle` low and 1 <= n <= T1, lengthens the bit by k = min(`sjw_len`, n): the next index is n-k.
- R7: An early edge, with `bus_idle` low and T1 < n < L, shortens the bit by k = min(`sjw_len`, L-n). If n+k reaches L, the bit ends at this tick and the next index is 0. Otherwise the next index is n+k.
- R8: An edge with n = 0, seen at the tick that leaves index L-1, causes no correction.
- R9: At most one correction is made per bit. Later edges in the same bit are ignored until the bit ends or a hard sync occurs.
- R10: No correction is made for an edge once the block has sampled dominant in the current bit, including at the sample tick itself.
- R11: After reset the strobes and `cfg_err` are 0, `rx_bit` is 1, the position is index 0, and the previous bus level is taken as recessive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tq_en | input | 1 | One-cycle time-quantum tick |
| rx_lvl | input | 1 | Synchronized bus level, 1 = recessive |
| bus_idle | input | 1 | High when an edge may hard-synchronize |
| prop_len | input | SEG_W | Propagation segment length in quanta |
| ph1_len | input | SEG_W | Phase segment 1 length in quanta |
| ph2_len | input | SEG_W | Phase segment 2 length in quanta |
| sjw_len | input | SEG_W | Resynchronization jump width in quanta |
| sample_stb | output | 1 | One-cycle strobe at the sample point |
| bit_end_stb | output | 1 | One-cycle strobe at the end of a bit |
| rx_bit | output | 1 | Bus level captured at the last sample point |
| cfg_err | output | 1 | Illegal timing configuration |

## Verification
The bench drives edges at sync, late, and early positions with jump widths that give both full and partial corrections. It covers a correction that takes the bit end onto the edge tick, and an edge landing on the sample tick. A design that measures the phase error off by one quantum, or that ignores the jump-width clamp, puts its sample and end strobes at the wrong ticks. The bench also places a second edge inside one bit, and a dominant-recessive-dominant glitch after a dominant sample. A design that corrects twice, or that corrects after sampling dominant, drifts away from the model. Illegal settings and a glitch between ticks check that the block neither counts nor strobes when it should not.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  // Region of the bit that an observed edge falls into
  typedef enum logic [1:0] {
    RGN_SYNC  = 2'd0,
    RGN_TSEG1 = 2'd1,
    RGN_PH2   = 2'd2
  } bt_region_e;
endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg #(
  parameter int SEG_W = 4,
  parameter int POS_W = SEG_W + 2
) (
  input  logic [SEG_W-1:0] prop_len,
  input  logic [SEG_W-1:0] ph1_len,
  input  logic [SEG_W-1:0] ph2_len,
  input  logic [SEG_W-1:0] sjw_len,
  output logic [POS_W-1:0] tseg1_last,
  output logic [POS_W-1:0] bit_last,
  output logic             cfg_bad
);
  localparam int PAD = POS_W - SEG_W;

  logic [POS_W-1:0] prop_x, ph1_x, ph2_x;

  always_comb begin
    prop_x     = {{PAD{1'b0}}, prop_len};
    ph1_x      = {{PAD{1'b0}}, ph1_len};
    ph2_x      = {{PAD{1'b0}}, ph2_len};
    tseg1_last = prop_x + ph1_x;
    bit_last   = tseg1_last + ph2_x;
    cfg_bad    = (ph2_len < SEG_W'(2)) || (sjw_len == '0) ||
                 (sjw_len > ph2_len) || (tseg1_last == '0);
  end
endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tq_en,
  input  logic rx_lvl,
  output logic fall_hit
);
  logic prev_q, prev_d;

  always_comb begin
    prev_d   = tq_en ? rx_lvl : prev_q;
    fall_hit = tq_en & prev_q & ~rx_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/can_bt_phase.sv
module can_bt_phase
  import can_bt_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int POS_W = SEG_W + 2
) (
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] tseg1_last,
  input  logic [POS_W-1:0] bit_last,
  input  logic [SEG_W-1:0] sjw_len,
  input  logic             fall_hit,
  input  logic             bus_idle,
  input  logic             rx_lvl,
  input  logic             rs_used,
  input  logic             sdom,
  output logic [POS_W-1:0] pos_nxt,
  output logic             rs_used_nxt,
  output logic             sdom_nxt,
  output logic             smp_hit,
  output logic             end_hit
);
  localparam int PAD = POS_W - SEG_W;

  logic [POS_W-1:0] n_idx, sjw_x, late_k, early_err, early_k, early_tgt;
  logic             is_last, is_smp, sdom_now, try_rs;
  bt_region_e       rgn;

  always_comb begin
    is_last   = (pos >= bit_last);
    is_smp    = (pos == tseg1_last);
    n_idx     = is_last ? '0 : pos + POS_W'(1);
    sjw_x     = {{PAD{1'b0}}, sjw_len};
    sdom_now  = sdom | (is_smp & ~rx_lvl);
    try_rs    = fall_hit & ~bus_idle & ~rs_used;
    if (n_idx == '0)               rgn = RGN_SYNC;
    else if (n_idx <= tseg1_last)  rgn = RGN_TSEG1;
    else                           rgn = RGN_PH2;
    late_k    = (sjw_x < n_idx) ? sjw_x : n_idx;
    early_err = bit_last + POS_W'(1) - n_idx;
    early_k   = (sjw_x < early_err) ? sjw_x : early_err;
    early_tgt = n_idx + early_k;
  end

  always_comb begin
    pos_nxt     = is_last ? '0 : pos + POS_W'(1);
    rs_used_nxt = is_last ? 1'b0 : rs_used;
    sdom_nxt    = is_last ? 1'b0 : sdom_now;
    smp_hit     = is_smp;
    end_hit     = is_last;
    if (fall_hit && bus_idle) begin
      pos_nxt     = '0;
      rs_used_nxt = 1'b0;
      sdom_nxt    = 1'b0;
      smp_hit     = 1'b0;
      end_hit     = 1'b0;
    end else if (try_rs && rgn == RGN_TSEG1) begin
      pos_nxt     = n_idx - late_k;
      rs_used_nxt = 1'b1;
    end else if (try_rs && rgn == RGN_PH2 && !sdom_now) begin
      if (early_tgt > bit_last) begin
        pos_nxt     = '0;
        rs_used_nxt = 1'b0;
        sdom_nxt    = 1'b0;
        end_hit     = 1'b1;
      end else begin
        pos_nxt     = early_tgt;
        rs_used_nxt = 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing #(
  parameter int SEG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_en,
  input  logic             rx_lvl,
  input  logic             bus_idle,
  input  logic [SEG_W-1:0] prop_len,
  input  logic [SEG_W-1:0] ph1_len,
  input  logic [SEG_W-1:0] ph2_len,
  input  logic [SEG_W-1:0] sjw_len,
  output logic             sample_stb,
  output logic             bit_end_stb,
  output logic             rx_bit,
  output logic             cfg_err
);
  localparam int POS_W = SEG_W + 2;

  logic [POS_W-1:0] tseg1_last, bit_last;
  logic             cfg_bad, fall_hit;
  logic [POS_W-1:0] pos_q, pos_d, ph_pos;
  logic             rs_q, rs_d, ph_rs;
  logic             sd_q, sd_d, ph_sd;
  logic             ph_smp, ph_end;
  logic             smp_d, end_d, bit_d;

  can_bt_cfg #(.SEG_W(SEG_W), .POS_W(POS_W)) u_cfg (
    .prop_len   (prop_len),
    .ph1_len    (ph1_len),
    .ph2_len    (ph2_len),
    .sjw_len    (sjw_len),
    .tseg1_last (tseg1_last),
    .bit_last   (bit_last),
    .cfg_bad    (cfg_bad)
  );

  can_bt_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .tq_en    (tq_en),
    .rx_lvl   (rx_lvl),
    .fall_hit (fall_hit)
  );

  can_bt_phase #(.SEG_W(SEG_W), .POS_W(POS_W)) u_phase (
    .pos         (pos_q),
    .tseg1_last  (tseg1_last),
    .bit_last    (bit_last),
    .sjw_len     (sjw_len),
    .fall_hit    (fall_hit),
    .bus_idle    (bus_idle),
    .rx_lvl      (rx_lvl),
    .rs_used     (rs_q),
    .sdom        (sd_q),
    .pos_nxt     (ph_pos),
    .rs_used_nxt (ph_rs),
    .sdom_nxt    (ph_sd),
    .smp_hit     (ph_smp),
    .end_hit     (ph_end)
  );

  // Next-state selection: configuration gate, then quantum enable
  always_comb begin
    pos_d = pos_q;
    rs_d  = rs_q;
    sd_d  = sd_q;
    smp_d = 1'b0;
    end_d = 1'b0;
    bit_d = rx_bit;
    if (cfg_bad) begin
      pos_d = '0;
      rs_d  = 1'b0;
      sd_d  = 1'b0;
    end else if (tq_en) begin
      pos_d = ph_pos;
      rs_d  = ph_rs;
      sd_d  = ph_sd;
      smp_d = ph_smp;
      end_d = ph_end;
      if (ph_smp) bit_d = rx_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q       <= '0;
      rs_q        <= 1'b0;
      sd_q        <= 1'b0;
      sample_stb  <= 1'b0;
      bit_end_stb <= 1'b0;
      rx_bit      <= 1'b1;
      cfg_err     <= 1'b0;
    end else begin
      pos_q       <= pos_d;
      rs_q        <= rs_d;
      sd_q        <= sd_d;
      sample_stb  <= smp_d;
      bit_end_stb <= end_d;
      rx_bit      <= bit_d;
      cfg_err     <= cfg_bad;
    end
  end
endmodule

// File: rtl/can_bit_timing_chk.sv
module can_bit_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic tq_en,
  input logic rx_lvl,
  input logic bus_idle,
  input logic sample_stb,
  input logic bit_end_stb,
  input logic rx_bit,
  input logic cfg_err
);
  logic ck_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ck_rx <= 1'b1;
    else if (tq_en) ck_rx <= rx_lvl;
  end

  AST_STROBE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb || bit_end_stb) |-> $past(tq_en)); // R4

  AST_SAMPLE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (rx_bit == $past(rx_lvl))); // R3

  AST_RX_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |-> $stable(rx_bit)); // R3

  AST_CFG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!sample_stb && !bit_end_stb)); // R1

  AST_HARD_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_en && bus_idle && ck_rx && !rx_lvl) |=> (!sample_stb && !bit_end_stb)); // R5

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_end_stb)); // R2
endmodule

bind can_bit_timing can_bit_timing_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tq_en       (tq_en),
  .rx_lvl      (rx_lvl),
  .bus_idle    (bus_idle),
  .sample_stb  (sample_stb),
  .bit_end_stb (bit_end_stb),
  .rx_bit      (rx_bit),
  .cfg_err     (cfg_err)
);

// File: tb/can_bit_timing_tb.sv
module can_bit_timing_tb;
  localparam int SEG_W = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tq_en, rx_lvl, bus_idle;
  logic [SEG_W-1:0] prop_len, ph1_len, ph2_len, sjw_len;
  logic sample_stb, bit_end_stb, rx_bit, cfg_err;

  can_bit_timing #(.SEG_W(SEG_W)) u_dut (
    .clk (clk), .rst_n (rst_n), .tq_en (tq_en), .rx_lvl (rx_lvl),
    .bus_idle (bus_idle), .prop_len (prop_len), .ph1_len (ph1_len),
    .ph2_len (ph2_len), .sjw_len (sjw_len), .sample_stb (sample_stb),
    .bit_end_stb (bit_end_stb), .rx_bit (rx_bit), .cfg_err (cfg_err)
  );

  int    n_vec = 0, n_bad = 0;
  string cur_req = "R11";
  bit    cmp_on = 0, done = 0;

  // Behavioural reference, one step per clock
  int m_pos, m_prev, m_rs, m_sd, e_smp, e_end, e_bit, e_cfg;

  always @(posedge clk) begin
    int t1, len, n, k;
    bit bad, fh, samp, last, sdn;
    if (!rst_n) begin
      m_pos = 0; m_prev = 1; m_rs = 0; m_sd = 0;
      e_smp = 0; e_end = 0; e_bit = 1; e_cfg = 0;
    end else begin
      t1  = int'(prop_len) + int'(ph1_len);
      len = t1 + 1 + int'(ph2_len);
      bad = (ph2_len < 2) || (sjw_len == 0) || (sjw_len > ph2_len) || (t1 == 0);
      e_cfg = bad; e_smp = 0; e_end = 0;
      fh = tq_en && (m_prev == 1) && !rx_lvl;
      if (bad) begin
        m_pos = 0; m_rs = 0; m_sd = 0;
      end else if (tq_en) begin
        last = (m_pos >= len - 1);
        n    = last ? 0 : m_pos + 1;
        if (fh && bus_idle) begin
          m_pos = 0; m_rs = 0; m_sd = 0;
        end else begin
          samp = (m_pos == t1);
          if (samp) begin e_smp = 1; e_bit = rx_lvl; end
          sdn = m_sd || (samp && !rx_lvl);
          if (fh && !m_rs && n >= 1 && n <= t1) begin
            k = (int'(sjw_len) < n) ? int'(sjw_len) : n;
            m_pos = n - k; m_rs = 1; m_sd = sdn;
          end else if (fh && !m_rs && !sdn && n > t1) begin
            k = (int'(sjw_len) < len - n) ? int'(sjw_len) : len - n;
            if (n + k >= len) begin
              e_end = 1; m_pos = 0; m_rs = 0; m_sd = 0;
            end else begin
              m_pos = n + k; m_rs = 1; m_sd = sdn;
            end
          end else if (last) begin
            e_end = 1; m_pos = 0; m_rs = 0; m_sd = 0;
          end else begin
            m_pos = m_pos + 1; m_sd = sdn;
          end
        end
      end
      if (tq_en) m_prev = rx_lvl;
    end
  end

  task automatic check(input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check("sample_stb", int'(sample_stb), e_smp);
      check("bit_end_stb", int'(bit_end_stb), e_end);
      check("rx_bit", int'(rx_bit), e_bit);
      check("cfg_err", int'(cfg_err), e_cfg);
    end
  end

  task automatic hold(input logic lvl, input int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk); rx_lvl = lvl; tq_en = 1'b1;
      @(negedge clk); tq_en = 1'b0;
      repeat (i % 3) @(negedge clk);
    end
  endtask

  task automatic glitch();
    @(negedge clk); rx_lvl = 1'b0;
    @(negedge clk); rx_lvl = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_cfg(input int p, input int a, input int b, input int j);
    @(negedge clk);
    prop_len = SEG_W'(p); ph1_len = SEG_W'(a); ph2_len = SEG_W'(b); sjw_len = SEG_W'(j);
  endtask

  task automatic traffic();
    cur_req = "R8";  hold(1, 9); hold(0, 9); hold(1, 9); hold(0, 9);
    cur_req = "R3";  hold(1, 9); hold(0, 9); hold(1, 9);
    cur_req = "R6";  hold(1, 1); hold(0, 9); hold(1, 11); hold(0, 9);
                     hold(1, 13); hold(0, 9); hold(1, 12); hold(0, 10);
    cur_req = "R7";  hold(1, 8); hold(0, 9); hold(1, 7); hold(0, 9);
                     hold(1, 6); hold(0, 8); hold(1, 5); hold(0, 9);
    cur_req = "R10"; hold(0, 9); hold(1, 1); hold(0, 9); hold(1, 1); hold(0, 6);
    cur_req = "R9";  hold(1, 11); hold(0, 1); hold(1, 1); hold(0, 8);
                     hold(1, 3); hold(0, 1); hold(1, 1); hold(0, 7);
    cur_req = "R2";  hold(1, 20); hold(0, 20);
  endtask

  task automatic resync_idle();
    bus_idle = 1'b1; hold(1, 2); hold(0, 1);
    @(negedge clk); bus_idle = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; tq_en = 1'b0; rx_lvl = 1'b1; bus_idle = 1'b1;
    prop_len = 4'd2; ph1_len = 4'd3; ph2_len = 4'd3; sjw_len = 4'd2;
    repeat (3) @(negedge clk);
    // R11: reset state at the ports
    cur_req = "R11";
    check("sample_stb", int'(sample_stb), 0);
    check("bit_end_stb", int'(bit_end_stb), 0);
    check("rx_bit", int'(rx_bit), 1);
    check("cfg_err", int'(cfg_err), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    cur_req = "R4";  hold(1, 4); glitch(); hold(1, 2); glitch();
    cur_req = "R5";  hold(0, 1);
    @(negedge clk); bus_idle = 1'b0;
    hold(0, 8);
    traffic();
    cur_req = "R1";
    set_cfg(2, 3, 1, 1); hold(1, 3); hold(0, 3);
    set_cfg(2, 3, 3, 4); hold(1, 3);
    set_cfg(2, 3, 3, 0); hold(0, 2);
    set_cfg(0, 0, 3, 2); hold(1, 3);
    set_cfg(2, 3, 2, 2); cur_req = "R5"; resync_idle(); hold(0, 6);
    cur_req = "R1"; hold(1, 8);
    set_cfg(1, 2, 6, 3); cur_req = "R5"; resync_idle(); hold(0, 9);
    traffic();
    set_cfg(0, 1, 4, 4); cur_req = "R5"; resync_idle(); hold(0, 5);
    traffic();
    set_cfg(3, 4, 7, 1); cur_req = "R5"; resync_idle(); hold(0, 14);
    traffic();
    cur_req = "R5"; bus_idle = 1'b1; hold(1, 5); hold(0, 3); hold(1, 4); hold(0, 2);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule